// File: doc/BRIEF.md
# Display Controller SPI Register Access Engine

This block is an SPI master that reads and writes the configuration registers of a display controller. Each access is split into frames. A frame is a run of bytes sent while chip select is held low. Every frame opens with a lead byte that says whether the frame addresses the index register or the data behind it, and whether the master writes or reads. A client issues one access at a time through a valid/ready request port. It supplies a register index, a 16-bit value and an operation code, and gets a one-cycle completion pulse. Reads and status reads also return a 16-bit result.

Four operations are supported: register write, register read, status read, and index-only. The index-only operation points the controller at a register and then stops. It is used, for example, to select the graphics-memory port before pixel data is streamed by other logic. The serial clock is divided down from the system clock so that register traffic stays below the controller's register-access clock limit. A per-request option transmits every byte bitwise inverted.

Top module: `dspi_regacc`

## Requirements
- R1: Every frame opens with a lead byte equal to 0x70 OR (id << 2) OR (sel << 1) OR dir. id is `cfg_id`. sel is 0 for the index register and 1 for register data. dir is 0 for write and 1 for read.
- R2: Operation code 0 (write) sends two frames. The first is {lead(sel=0,dir=0), 0x00, index}. The second is {lead(sel=1,dir=0), value[15:8], value[7:0]}.
- R3: Operation code 1 (read) sends the same index frame, then {lead(sel=1,dir=1), 0x00, 0x00}. The result is the second byte received in that second frame (upper half) followed by the third byte (lower half).
- R4: Operation code 2 (status) sends one frame {lead(sel=0,dir=1), 0x00, 0x00, 0x00}. The byte received right after the lead byte is discarded. The result is the third received byte (upper half) followed by the fourth (lower half).
- R5: Operation code 3 (index-only) sends only the frame {lead(sel=0,dir=0), 0x00, index}.
- R6: When `cfg_invert` is 1 at acceptance, every byte of that access, dummy bytes included, is sent bitwise inverted.
- R7: SPI mode 0 is used, with MSB first. `sclk` is low whenever `cs_n` is high. MOSI is valid before each rising edge of `sclk`, and MISO is sampled on that rising edge.
- R8: Each high phase and each low phase of `sclk` lasts at least CLK_DIV system clock cycles.
- R9: `cs_n` goes high after every frame. It stays high for at least GAP_TICKS*CLK_DIV cycles before the next frame begins, and this holds within an access and between accesses.
- R10: `req_ready` is high only when the engine is idle. A request is taken when `req_valid` and `req_ready` are both high. Requests presented while busy are ignored and cause no extra frames.
- R11: `done` is high for exactly one cycle at the end of every access. `rdata` changes only on that cycle and only for read or status operations, so writes and index-only operations leave it unchanged.
- R12: After reset, `cs_n`=1, `sclk`=0, `mosi`=0, `req_ready`=1, `done`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_op | input | 2 | 0 write, 1 read, 2 status, 3 index-only |
| req_index | input | 8 | Register index |
| req_wdata | input | 16 | Value for a write |
| cfg_id | input | 1 | Identifier bit placed in every lead byte |
| cfg_invert | input | 1 | Send all bytes of the access inverted |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | 16 | Result of the last read or status access |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the controller |
| miso | input | 1 | Serial data from the controller |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the engine with CLK_DIV=2 and GAP_TICKS=2. Each serial phase is then two system cycles, and each access takes a few hundred cycles, so dozens of random accesses of all four kinds fit in a short run. At this small divider the restart of the tick counter at every byte hand-off has the greatest relative effect on phase length. That makes the minimum half-period and chip-select gap checks meaningful at their exact bounds. Random response bytes from the modelled controller include a garbage byte after the status lead byte, which tests that this byte is dropped.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

    localparam int IDX_W  = 8;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_READ   = 2'd1,
        OP_STATUS = 2'd2,
        OP_INDEX  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_HOLD,
        ST_GAP
    } seq_st_e;

    // Lead byte: fixed pattern 0111_0 then id, selector, direction.
    function automatic logic [7:0] lead_byte(input logic id, input logic sel, input logic rd);
        return {5'b01110, id, sel, rd};
    endfunction

    function automatic logic two_frames(input op_e op);
        return (op == OP_WRITE) || (op == OP_READ);
    endfunction

    // Position of the final byte within a frame.
    function automatic logic [1:0] last_pos(input op_e op);
        return (op == OP_STATUS) ? 2'd3 : 2'd2;
    endfunction

    function automatic logic [7:0] frame_byte(
        input op_e                op,
        input logic               frame,
        input logic [1:0]         pos,
        input logic               id,
        input logic [IDX_W-1:0]   idx,
        input logic [DATA_W-1:0]  wdata,
        input logic               inv
    );
        logic [7:0] raw;
        raw = 8'h00;
        if (!frame) begin
            case (pos)
                2'd0:    raw = lead_byte(id, 1'b0, op == OP_STATUS);
                2'd2:    raw = (op == OP_STATUS) ? 8'h00 : idx;
                default: raw = 8'h00;
            endcase
        end else begin
            case (pos)
                2'd0:    raw = lead_byte(id, 1'b1, op == OP_READ);
                2'd1:    raw = (op == OP_WRITE) ? wdata[15:8] : 8'h00;
                2'd2:    raw = (op == OP_WRITE) ? wdata[7:0] : 8'h00;
                default: raw = 8'h00;
            endcase
        end
        return inv ? ~raw : raw;
    endfunction

endpackage

// File: rtl/dspi_tick.sv
module dspi_tick #(
    parameter int CLK_DIV = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == CNT_LAST);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (restart_i || tick_o) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/dspi_shift.sv
module dspi_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       load_i,
    input  logic [7:0] load_byte_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic [7:0] rx_byte_o,
    output logic       byte_done_o
);
    typedef struct packed {
        logic       active;
        logic       sclk;
        logic [2:0] bitcnt;
        logic [7:0] tx;
        logic [7:0] rx;
    } shift_t;

    shift_t d, q;

    assign sclk_o      = q.sclk;
    assign mosi_o      = q.active & q.tx[7];
    assign rx_byte_o   = q.rx;
    assign byte_done_o = q.active & tick_i & q.sclk & (q.bitcnt == 3'd7);

    always_comb begin
        d = q;
        if (load_i) begin
            d.active = 1'b1;
            d.sclk   = 1'b0;
            d.bitcnt = 3'd0;
            d.tx     = load_byte_i;
        end else if (q.active && tick_i) begin
            if (!q.sclk) begin
                d.sclk = 1'b1;
                d.rx   = {q.rx[6:0], miso_i};
            end else begin
                d.sclk = 1'b0;
                if (q.bitcnt == 3'd7) begin
                    d.active = 1'b0;
                end else begin
                    d.bitcnt = q.bitcnt + 3'd1;
                    d.tx     = {q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dspi_seq.sv
module dspi_seq
    import dspi_pkg::*;
#(
    parameter int GAP_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [1:0]        req_op_i,
    input  logic [IDX_W-1:0]  req_index_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              cfg_id_i,
    input  logic              cfg_invert_i,
    input  logic              tick_i,
    input  logic              byte_done_i,
    input  logic [7:0]        rx_byte_i,
    output logic              req_ready_o,
    output logic              load_o,
    output logic [7:0]        load_byte_o,
    output logic              restart_o,
    output logic              cs_n_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int GW = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_TICKS - 1);

    typedef struct packed {
        seq_st_e           st;
        op_e               op;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
        logic              id;
        logic              inv;
        logic              frame;
        logic [1:0]        pos;
        logic [GW-1:0]     gcnt;
        logic [DATA_W-1:0] acc;
        logic              cs_n;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t d, q;

    assign req_ready_o = (q.st == ST_IDLE);
    assign cs_n_o      = q.cs_n;
    assign done_o      = q.done;
    assign rdata_o     = q.rdata;

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        load_o      = 1'b0;
        load_byte_o = 8'h00;
        restart_o   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                restart_o = 1'b1;
                if (req_valid_i) begin
                    d.st    = ST_XFER;
                    d.op    = op_e'(req_op_i);
                    d.idx   = req_index_i;
                    d.wdata = req_wdata_i;
                    d.id    = cfg_id_i;
                    d.inv   = cfg_invert_i;
                    d.frame = 1'b0;
                    d.pos   = 2'd0;
                    d.cs_n  = 1'b0;
                    load_o  = 1'b1;
                    load_byte_o = frame_byte(op_e'(req_op_i), 1'b0, 2'd0, cfg_id_i,
                                             req_index_i, req_wdata_i, cfg_invert_i);
                end
            end
            ST_XFER: begin
                if (byte_done_i) begin
                    d.acc     = {q.acc[7:0], rx_byte_i};
                    restart_o = 1'b1;
                    if (q.pos == last_pos(q.op)) begin
                        d.st = ST_HOLD;
                    end else begin
                        d.pos  = q.pos + 2'd1;
                        load_o = 1'b1;
                        load_byte_o = frame_byte(q.op, q.frame, q.pos + 2'd1, q.id,
                                                 q.idx, q.wdata, q.inv);
                    end
                end
            end
            ST_HOLD: begin
                if (tick_i) begin
                    d.cs_n = 1'b1;
                    d.st   = ST_GAP;
                    d.gcnt = '0;
                end
            end
            ST_GAP: begin
                if (tick_i) begin
                    if (q.gcnt == GAP_LAST) begin
                        if (!q.frame && two_frames(q.op)) begin
                            d.st      = ST_XFER;
                            d.frame   = 1'b1;
                            d.pos     = 2'd0;
                            d.cs_n    = 1'b0;
                            load_o    = 1'b1;
                            restart_o = 1'b1;
                            load_byte_o = frame_byte(q.op, 1'b1, 2'd0, q.id,
                                                     q.idx, q.wdata, q.inv);
                        end else begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                            if (q.op == OP_READ || q.op == OP_STATUS) begin
                                d.rdata = q.acc;
                            end
                        end
                    end else begin
                        d.gcnt = q.gcnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.op    <= OP_WRITE;
            q.cs_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dspi_regacc.sv
module dspi_regacc
    import dspi_pkg::*;
#(
    parameter int CLK_DIV   = 13,
    parameter int GAP_TICKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_op,
    input  logic [7:0]  req_index,
    input  logic [15:0] req_wdata,
    input  logic        cfg_id,
    input  logic        cfg_invert,
    output logic        done,
    output logic [15:0] rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n
);
    logic       tick;
    logic       restart;
    logic       load;
    logic [7:0] load_byte;
    logic [7:0] rx_byte;
    logic       byte_done;

    dspi_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .tick_o    (tick)
    );

    dspi_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .load_i      (load),
        .load_byte_i (load_byte),
        .miso_i      (miso),
        .sclk_o      (sclk),
        .mosi_o      (mosi),
        .rx_byte_o   (rx_byte),
        .byte_done_o (byte_done)
    );

    dspi_seq #(.GAP_TICKS(GAP_TICKS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_op_i     (req_op),
        .req_index_i  (req_index),
        .req_wdata_i  (req_wdata),
        .cfg_id_i     (cfg_id),
        .cfg_invert_i (cfg_invert),
        .tick_i       (tick),
        .byte_done_i  (byte_done),
        .rx_byte_i    (rx_byte),
        .req_ready_o  (req_ready),
        .load_o       (load),
        .load_byte_o  (load_byte),
        .restart_o    (restart),
        .cs_n_o       (cs_n),
        .done_o       (done),
        .rdata_o      (rdata)
    );
endmodule

// File: rtl/dspi_regacc_chk.sv
module dspi_regacc_chk #(
    parameter int CLK_DIV   = 13,
    parameter int GAP_TICKS = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sclk,
    input logic        cs_n,
    input logic        req_ready,
    input logic        done,
    input logic [15:0] rdata
);
    localparam logic [15:0] HALF_MIN = 16'(CLK_DIV);
    localparam logic [15:0] GAP_MIN  = 16'(GAP_TICKS * CLK_DIV);

    logic        sclk_prev_q;
    logic [15:0] run_q;
    logic [15:0] hi_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            run_q       <= '0;
            hi_run_q    <= '0;
        end else begin
            sclk_prev_q <= sclk;
            if (sclk != sclk_prev_q) begin
                run_q <= 16'd1;
            end else if (run_q != 16'hFFFF) begin
                run_q <= run_q + 16'd1;
            end
            if (!cs_n) begin
                hi_run_q <= '0;
            end else if (hi_run_q != 16'hFFFF) begin
                hi_run_q <= hi_run_q + 16'd1;
            end
        end
    end

    // R7: serial clock rests low while the device is deselected
    a_r7_sclk_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R8: each clock phase held for at least CLK_DIV cycles
    a_r8_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != sclk_prev_q) |-> (run_q >= HALF_MIN));

    // R9: deselect time before a frame starts
    a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_run_q >= GAP_MIN));

    // R10: a selected device means the engine is busy
    a_r10_busy_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !req_ready);

    // R11: completion is a single-cycle pulse, seen while idle
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    // R11: result register only moves on a completion pulse
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rdata));
endmodule

bind dspi_regacc dspi_regacc_chk #(.CLK_DIV(CLK_DIV), .GAP_TICKS(GAP_TICKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .req_ready (req_ready),
    .done      (done),
    .rdata     (rdata)
);

// File: tb/dspi_regacc_test.sv
module dspi_regacc_test;
    localparam int DIV = 2;
    localparam int GAP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_index = 8'h00;
    logic [15:0] req_wdata = 16'h0000;
    logic        cfg_id = 1'b1;
    logic        cfg_invert = 1'b0;
    logic        req_ready, done, sclk, mosi, cs_n, miso;
    logic [15:0] rdata;

    dspi_regacc #(.CLK_DIV(DIV), .GAP_TICKS(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_index(req_index), .req_wdata(req_wdata),
        .cfg_id(cfg_id), .cfg_invert(cfg_invert), .done(done), .rdata(rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Controller model: returns response bits MSB first, captures MOSI on rising sclk.
    logic [31:0] resp0 = 0, resp1 = 0, cur_resp;
    int base_nfr = 0;
    int nfr = 0;
    int k = 0;
    logic [31:0] sh = 0;
    logic [31:0] cap_data [0:255];
    int cap_bits [0:255];

    assign cur_resp = (nfr == base_nfr) ? resp0 : resp1;
    assign miso = (k < 32) ? cur_resp[31-k] : 1'b0;

    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            if (nfr < 256) begin
                cap_data[nfr] = sh;
                cap_bits[nfr] = k;
            end
            nfr++;
            k = 0;
            sh = 0;
        end else begin
            sh = {sh[30:0], mosi};
            k++;
        end
    end

    // Timing monitors
    int done_cnt = 0;
    int srun = 0, crun = 0;
    int min_half = 1000000, min_gap = 1000000;
    logic sclk_prev = 1'b0, cs_prev = 1'b1;
    always @(negedge clk) begin
        if (done === 1'b1) done_cnt++;
        if (sclk === sclk_prev) srun++;
        else begin
            if (rst_n && srun < min_half) min_half = srun;
            srun = 1;
        end
        sclk_prev = sclk;
        if (cs_n === 1'b1) crun++;
        else begin
            if (cs_prev === 1'b1 && rst_n && nfr > base_nfr && crun < min_gap) min_gap = crun;
            crun = 0;
        end
        cs_prev = cs_n;
    end

    function automatic logic [7:0] lead(input logic id, input logic sel, input logic rd);
        return 8'h70 | (8'(id) << 2) | (8'(sel) << 1) | 8'(rd);
    endfunction

    function automatic int nbytes(input int op);
        return (op == 2) ? 4 : 3;
    endfunction

    function automatic int nframes(input int op);
        return (op <= 1) ? 2 : 1;
    endfunction

    function automatic logic [31:0] exp_frame(input int op, input int fr, input logic [7:0] idx,
                                              input logic [15:0] wd, input logic id, input logic inv);
        logic [31:0] v;
        if (op == 2) v = {lead(id, 1'b0, 1'b1), 24'h000000};
        else if (fr == 0) v = {8'h00, lead(id, 1'b0, 1'b0), 8'h00, idx};
        else if (op == 0) v = {8'h00, lead(id, 1'b1, 1'b0), wd};
        else v = {8'h00, lead(id, 1'b1, 1'b1), 16'h0000};
        if (inv) v = (op == 2) ? ~v : {8'h00, ~v[23:0]};
        return v;
    endfunction

    logic [15:0] exp_rd = 16'h0000;

    task automatic run_access(input int op, input logic [7:0] idx, input logic [15:0] wd,
                              input logic id, input logic inv,
                              input logic [31:0] r0, input logic [31:0] r1, input bit poke);
        string tag;
        int d0, w, nf;
        tag = (op == 0) ? "R2" : (op == 1) ? "R3" : (op == 2) ? "R4" : "R5";
        @(negedge clk);
        resp0 = r0; resp1 = r1; base_nfr = nfr; d0 = done_cnt;
        req_op = 2'(op); req_index = idx; req_wdata = wd; cfg_id = id; cfg_invert = inv;
        req_valid = 1'b1;
        @(negedge clk);
        if (poke) begin
            // R10: a second request held while busy must be ignored
            req_op = 2'd0; req_index = ~idx; req_wdata = ~wd; cfg_invert = ~inv;
            for (int i = 0; i < 60; i++) begin
                check(req_ready === 1'b0, "R10 ready while busy", 32'(req_ready), 32'd0);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        w = 0;
        while (done !== 1'b1 && w < 5000) begin
            @(negedge clk);
            w++;
        end
        @(negedge clk);
        check(done_cnt - d0 == 1, "R11 done pulse count", 32'(done_cnt - d0), 32'd1);
        nf = nfr - base_nfr;
        check(nf == nframes(op), {tag, " R10 frame count"}, 32'(nf), 32'(nframes(op)));
        for (int fr = 0; fr < nframes(op) && fr < nf; fr++) begin
            logic [31:0] e, a;
            int nb;
            nb = (fr == 0) ? nbytes(op) : 3;
            a = cap_data[base_nfr + fr];
            if (nb == 3) a = {8'h00, a[23:0]};
            e = exp_frame(op, fr, idx, wd, id, inv);
            check(cap_bits[base_nfr + fr] == 8 * nb, {tag, " R7 bit count"},
                  32'(cap_bits[base_nfr + fr]), 32'(8 * nb));
            check(a == e, {tag, inv ? " R6" : "", " R1 R7 frame bytes"}, a, e);
        end
        if (op == 1) exp_rd = r1[23:8];
        if (op == 2) exp_rd = r0[15:0];
        check(rdata == exp_rd, {tag, " R11 rdata"}, 32'(rdata), 32'(exp_rd));
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        // R12: reset values
        check(cs_n === 1'b1, "R12 cs_n", 32'(cs_n), 32'd1);
        check(sclk === 1'b0, "R12 sclk", 32'(sclk), 32'd0);
        check(mosi === 1'b0, "R12 mosi", 32'(mosi), 32'd0);
        check(req_ready === 1'b1, "R12 ready", 32'(req_ready), 32'd1);
        check(done === 1'b0, "R12 done", 32'(done), 32'd0);
        check(rdata === 16'h0000, "R12 rdata", 32'(rdata), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_access(0, 8'h10, 16'h4240, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0);          // R1 R2
        run_access(1, 8'h00, 16'h0000, 1'b1, 1'b0, 32'h0, 32'h00922100, 1'b0);   // R3
        run_access(2, 8'h00, 16'h0000, 1'b0, 1'b0, 32'h00EE1234, 32'h0, 1'b0);   // R4 garbage byte
        run_access(3, 8'h22, 16'hFFFF, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0);          // R5
        run_access(0, 8'h0C, 16'h0110, 1'b1, 1'b1, 32'h0, 32'h0, 1'b0);          // R6
        run_access(1, 8'h07, 16'h0000, 1'b0, 1'b0, 32'h0, 32'h00ABCD00, 1'b1);   // R10
        run_access(0, 8'h01, 16'h691B, 1'b0, 1'b0, 32'h0, 32'h00FFFF00, 1'b0);   // R11 rdata kept
        run_access(2, 8'h00, 16'h0000, 1'b1, 1'b1, 32'h00FF8001, 32'h0, 1'b0);   // R4 R6

        for (int i = 0; i < 40; i++) begin
            run_access(int'($urandom % 4), 8'($urandom), 16'($urandom), 1'($urandom),
                       1'($urandom), $urandom, $urandom, ($urandom % 8) == 0);
        end

        check(min_half >= DIV, "R8 min half period", 32'(min_half), 32'(DIV));
        check(min_gap >= GAP * DIV, "R9 min cs gap", 32'(min_gap), 32'(GAP * DIV));
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule